// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is a five-pin general-purpose I/O port seen by software through four small registers: a pin-direction mask, an output data latch, a synchronized view of the pad levels, and a two-bit configuration word. Each pin is modelled at the pad as a tri-state driver: an output enable, a driven value, an input value and a pull-up request.

Each pin also takes a pair of force inputs from neighbouring peripherals. A peripheral may claim a pin as an output and drive its own data, or hold it as an input. The stored direction mask does not change in either case, so software can read, modify and write the mask without capturing the peripheral's claim. A global pull-up enable turns on weak pull-ups for every pin that is not currently driving. One pin, chosen by parameter and used for serial transmit, can be switched to open-drain, where it pulls low and releases high.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction mask reads 0x1F (all inputs), the latch reads 0, the configuration reads 0, no pad is enabled and no pull-up is requested.
- R2: A pin whose direction bit is 0 and that has no force has its pad output enabled and drives its latch bit. A direction bit of 1 releases the pad. Writing 0x04 to the direction mask enables every pad except pin 2.
- R3: A write to address 0 (pin address) or to address 1 (latch address) loads the output latch. Reading address 1 returns the latch.
- R4: Reading address 0 returns the pad input levels after two clock edges of synchronization. The value seen after one edge is still the previous level.
- R5: An asserted output force on a pin enables its pad and drives the peripheral's data in place of the latch, whatever the direction bit. It takes priority over an input force on the same pin.
- R6: An asserted input force on a pin whose direction bit is 0 releases that pad.
- R7: Forces never alter the direction mask. Address 2 reads back exactly what software last wrote.
- R8: Address 3 holds the pull-up enable in bit 0 and the open-drain enable in bit 1, and reads back both bits. A pin's pull-up request is set exactly when the pull-up enable is 1 and the pin is not acting as an output, whether it is an output by direction or by force.
- R9: With open-drain enabled, the designated pin (pin 3 by default) enables its pad only while its data is 0, and never drives a 1, whether the data comes from the latch or from a peripheral. The other pins are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 pins, 1 latch, 2 direction, 3 configuration |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 5 | Read data for bus_addr (combinational) |
| frc_out | input | 5 | Per-pin peripheral output force |
| frc_in | input | 5 | Per-pin peripheral input force |
| frc_data | input | 5 | Peripheral data used under output force |
| pad_in | input | 5 | Pad input levels |
| pad_oe | output | 5 | Pad output enables |
| pad_out | output | 5 | Pad drive values |
| pad_pu | output | 5 | Weak pull-up requests |

## Verification
The pin multiplexer is exercised with direction-only patterns, such as the 0x04 mask and latch values of alternating bits, which show whether each pad follows its own direction and latch bit. Output-force patterns that disagree with both the latch and the direction separate force priority from normal port data. Overlapping output and input forces on the same pin confirm which force wins. Pull-up patterns mix inputs, direction outputs and forced pins, and open-drain patterns drive 0 and 1 from both latch and peripheral to show that only the designated pin changes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      SEL_PINS  = 2'd0,
      SEL_LATCH = 2'd1,
      SEL_DIR   = 2'd2,
      SEL_CFG   = 2'd3
   } reg_sel_e;

   localparam int CFG_PU_BIT = 0;
   localparam int CFG_OD_BIT = 1;
   localparam int CFG_BITS   = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_async;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_sync = stage_q[STAGES-1];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] warm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) warm_q <= '0;
            else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
         end
         // R4
         sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2) |-> (q_sync == $past(d_async, 2)));
      end
   endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [1:0]   addr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_sync,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lat_q,
   output logic         pu_en,
   output logic         od_en,
   output logic [W-1:0] rdata
);
   generate
      if (W < CFG_BITS) begin : g_bad_w
         $error("gpio_regs data width too small for the configuration word");
      end
   endgenerate

   logic [CFG_BITS-1:0] cfg_q;
   logic                lat_hit;

   assign lat_hit = we && (addr == SEL_PINS || addr == SEL_LATCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         lat_q <= '0;
         cfg_q <= '0;
      end else begin
         if (lat_hit) lat_q <= wdata;
         if (we && addr == SEL_DIR) dir_q <= wdata;
         if (we && addr == SEL_CFG) cfg_q <= wdata[CFG_BITS-1:0];
      end
   end

   assign pu_en = cfg_q[CFG_PU_BIT];
   assign od_en = cfg_q[CFG_OD_BIT];

   always_comb begin
      rdata = '0;
      unique case (addr)
         SEL_PINS:  rdata = pin_sync;
         SEL_LATCH: rdata = lat_q;
         SEL_DIR:   rdata = dir_q;
         SEL_CFG:   rdata[CFG_BITS-1:0] = cfg_q;
         default:   rdata = '0;
      endcase
   end

   // R1
   reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dir_q == '1 && lat_q == '0 && cfg_q == '0));
   // R3
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_hit |=> (lat_q == $past(wdata)));
   // R7
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == SEL_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell #(
   parameter bit OD_CAPABLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_bit,
   input  logic lat_bit,
   input  logic frc_out,
   input  logic frc_in,
   input  logic frc_data,
   input  logic pu_en,
   input  logic od_en,
   output logic oe,
   output logic dout,
   output logic pu
);
   logic drives;
   logic val;

   assign drives = frc_out | (~frc_in & ~dir_bit);
   assign val    = frc_out ? frc_data : lat_bit;
   assign dout   = val;
   assign pu     = pu_en & ~drives;

   generate
      if (OD_CAPABLE) begin : g_od
         assign oe = drives & ~(od_en & val);
         // R9
         od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            od_en |-> !(oe && dout));
      end else begin : g_push_pull
         logic unused_od;
         assign unused_od = od_en;
         assign oe = drives;
      end
   endgenerate

   // R5
   force_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_out && !(OD_CAPABLE && od_en)) |-> (oe && dout == frc_data));
   // R6
   force_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_in && !frc_out) |-> !oe);
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_pkg::*;
#(
   parameter int W      = 5,
   parameter int OD_PIN = 3,
   parameter int SYNC   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bus_we,
   input  logic [1:0]   bus_addr,
   input  logic [W-1:0] bus_wdata,
   output logic [W-1:0] bus_rdata,
   input  logic [W-1:0] frc_out,
   input  logic [W-1:0] frc_in,
   input  logic [W-1:0] frc_data,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_pu
);
   generate
      if (W < 1 || W > 32) begin : g_bad_w
         $error("gpio_ovr_port width out of range");
      end
      if (OD_PIN < 0 || OD_PIN >= W) begin : g_bad_od
         $error("gpio_ovr_port open-drain pin outside the port");
      end
   endgenerate

   logic [W-1:0] pin_sync;
   logic [W-1:0] dir_q;
   logic [W-1:0] lat_q;
   logic         pu_en;
   logic         od_en;

   gpio_sync #(.W(W), .STAGES(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pin_sync)
   );

   gpio_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .pin_sync(pin_sync), .dir_q(dir_q),
      .lat_q(lat_q), .pu_en(pu_en), .od_en(od_en), .rdata(bus_rdata)
   );

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         gpio_pin_cell #(.OD_CAPABLE(i == OD_PIN)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .dir_bit(dir_q[i]), .lat_bit(lat_q[i]),
            .frc_out(frc_out[i]), .frc_in(frc_in[i]), .frc_data(frc_data[i]),
            .pu_en(pu_en), .od_en(od_en),
            .oe(pad_oe[i]), .dout(pad_out[i]), .pu(pad_pu[i])
         );
      end
   endgenerate

   // R8
   pu_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);
   // R8
   pu_global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pu_en |-> (pad_pu == '0));
endmodule

// File: tb/sim_gpio_ovr_port.sv
module sim_gpio_ovr_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [4:0] bus_wdata = '0;
   logic [4:0] bus_rdata;
   logic [4:0] frc_out = '0, frc_in = '0, frc_data = '0, pad_in = '0;
   logic [4:0] pad_oe, pad_out, pad_pu;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   gpio_ovr_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frc_out(frc_out),
      .frc_in(frc_in), .frc_data(frc_data), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [4:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [4:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [4:0] v;
      rd(2'd2, v); check("R1 dir", v, 5'h1F);
      rd(2'd1, v); check("R1 latch", v, 5'h00);
      rd(2'd3, v); check("R1 cfg", v, 5'h00);
      check("R1 oe", pad_oe, 5'h00);
      check("R1 pu", pad_pu, 5'h00);
   endtask

   task automatic t_direction();
      wr(2'd1, 5'h15);
      wr(2'd2, 5'h04);
      #1;
      check("R2 oe 0x04", pad_oe, 5'h1B);
      check("R2 out", pad_out & pad_oe, 5'h11);
      wr(2'd2, 5'h1F);
      #1;
      check("R2 all input", pad_oe, 5'h00);
   endtask

   task automatic t_latch();
      logic [4:0] v;
      wr(2'd0, 5'h0A);
      rd(2'd1, v); check("R3 via pin addr", v, 5'h0A);
      wr(2'd1, 5'h00);
      rd(2'd1, v); check("R3 via latch addr", v, 5'h00);
   endtask

   task automatic t_sync();
      logic [4:0] v;
      @(negedge clk);
      pad_in = 5'h15;
      @(negedge clk);
      rd(2'd0, v); check("R4 one edge", v, 5'h00);
      @(negedge clk);
      rd(2'd0, v); check("R4 two edges", v, 5'h15);
      pad_in = 5'h0A;
      @(negedge clk); @(negedge clk);
      rd(2'd0, v); check("R4 second pattern", v, 5'h0A);
   endtask

   task automatic t_force();
      logic [4:0] v;
      wr(2'd1, 5'h00);
      wr(2'd2, 5'h1C);
      @(negedge clk);
      frc_out = 5'h14; frc_data = 5'h10;
      #1;
      check("R5 oe", pad_oe, 5'h17);
      check("R5 data", pad_out, 5'h10);
      frc_in = 5'h05;
      #1;
      check("R5 priority over in-force", pad_oe, 5'h16);
      check("R6 in-force releases pin 0", pad_oe[0], 1'b0);
      rd(2'd2, v); check("R7 dir kept", v, 5'h1C);
      frc_out = '0; frc_in = '0; frc_data = '0;
      #1;
      check("R7 back to dir", pad_oe, 5'h03);
   endtask

   task automatic t_pullup();
      logic [4:0] v;
      wr(2'd2, 5'h1F);
      wr(2'd3, 5'h01);
      rd(2'd3, v); check("R8 cfg readback", v, 5'h01);
      check("R8 all pu", pad_pu, 5'h1F);
      wr(2'd2, 5'h1C);
      #1;
      check("R8 dir outputs", pad_pu, 5'h1C);
      @(negedge clk);
      frc_out = 5'h04; frc_in = 5'h01;
      #1;
      check("R8 forces", pad_pu, 5'h19);
      frc_out = '0; frc_in = '0;
      wr(2'd3, 5'h00);
      #1;
      check("R8 global off", pad_pu, 5'h00);
   endtask

   task automatic t_opendrain();
      logic [4:0] v;
      wr(2'd2, 5'h16);
      wr(2'd3, 5'h02);
      rd(2'd3, v); check("R8 od readback", v, 5'h02);
      wr(2'd1, 5'h09);
      #1;
      check("R9 high released", pad_oe, 5'h01);
      wr(2'd1, 5'h01);
      #1;
      check("R9 low driven", pad_oe, 5'h09);
      check("R9 low value", pad_out & pad_oe, 5'h01);
      @(negedge clk);
      frc_out = 5'h08; frc_data = 5'h08;
      #1;
      check("R9 forced high released", pad_oe, 5'h01);
      frc_data = 5'h00;
      #1;
      check("R9 forced low driven", pad_oe, 5'h09);
      frc_out = '0; frc_data = '0;
      wr(2'd3, 5'h00);
      wr(2'd1, 5'h08);
      #1;
      check("R9 push-pull high", pad_oe & pad_out, 5'h08);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction();
      t_latch();
      t_sync();
      t_force();
      t_pullup();
      t_opendrain();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule